// File: doc/BRIEF.md
# CSR Access Instruction Unit

This block carries out the six control/status register instructions of one hart: swap, set bits and clear bits, each in a register-operand form and an immediate form. It works on a small set of CSRs. Each CSR has a 12-bit address, a reset value and a mask of writable bits, and all three are given by parameters. Each instruction arrives as a single valid cycle. The cycle carries funct3, the 12-bit CSR address, the rd and rs1 indices, and the rs1 register value. In that same cycle the unit returns the old CSR value for rd, a read strobe, a write strobe, the merged value to be written, and an illegal-instruction flag. The write commits at the next rising clock edge.

The read and write strobes are meant to drive side-effect hooks outside the block. Whether a read or a write takes place depends on register indices, not on operand values. For a swap, rd naming x0 removes the read. For set and clear, rs1 naming x0 (or a zero immediate) removes the write. A write that does not happen cannot fault on a read-only CSR, so such an access stays legal.

Top module: `csr_exec_unit`

## Requirements
- R1: funct3 selects the operation: 001 swap, 010 set, 011 clear, and the same three with bit 2 set (101, 110, 111) take their operand from the 5-bit rs1 field. funct3 000 or 100 raises illegal_o, with both strobes low.
- R2: Swap always writes. The new value is (old & ~mask) | (operand & mask), where mask is the writable mask. When rd_idx_i is 0, swap raises no read strobe and returns 0 on rdata. With rs1 naming x0, the operand is that register's zero value, so swap writes 0 into the writable bits.
- R3: Set produces old | (operand & mask). Clear produces old & ~(operand & mask).
- R4: Set or clear with rs1_idx_i equal to 0 (register form: x0; immediate form: zero immediate) raises no write strobe and changes no CSR. It raises no illegal flag, even on a read-only address.
- R5: Set or clear with a nonzero rs1 index whose value is zero still raises the write strobe and writes back the unchanged value.
- R6: Set and clear always raise the read strobe, whatever rd and rs1 name.
- R7: The immediate forms use the rs1 field, zero-extended to XLEN, as the operand.
- R8: When the read strobe is high, rdata_o is the CSR contents from before this instruction. Otherwise rdata_o is 0.
- R9: Addresses with bits [11:10] = 11 are read-only. Any access to one that would write it raises illegal_o, leaves both strobes low and commits nothing.
- R10: An address that matches no implemented CSR raises illegal_o, with both strobes low and no commit.
- R11: After reset the defaults hold: 0x340 = 0x00000000 (mask 0xFFFFFFFF), 0x300 = 0x00001800 (mask 0x00000088), 0x7C0 = 0x000000A5 (mask 0x000000FF), 0xC01 = 0x12345678 (mask 0). Bits outside the mask never change.
- R12: A value written with the write strobe is what the next instruction reads from that CSR.
- R13: With valid_i low, no strobe and no illegal flag is raised and no CSR changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| funct3_i | input | 3 | Operation select |
| csr_addr_i | input | 12 | CSR address field |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | Source index, or the immediate in immediate forms |
| rs1_val_i | input | XLEN | Source register value |
| rdata_o | output | XLEN | Old CSR value for rd |
| re_o | output | 1 | CSR read performed |
| we_o | output | 1 | CSR write performed |
| wdata_o | output | XLEN | Value committed on this write |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The bench targets the suppression corners, where index and value disagree. A set with a nonzero rs1 index holding zero must still raise the write strobe; a design keyed on the operand value would drop it. A clear through x0 carrying a nonzero value must write nothing; a design keyed on the value would clear bits. Set through x0 to the read-only CSR must stay legal, and a design that treats every set as a write would fault there. A swap with rd = x0 must not read, so a design that always reads would fire a spurious read hook. The bench also checks masked merges on partly writable CSRs, zero-extension of the immediate, and that rejected writes to read-only and unimplemented addresses commit nothing.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  typedef enum logic [1:0] {
    CSR_OP_NONE = 2'b00,
    CSR_OP_SWAP = 2'b01,
    CSR_OP_SET  = 2'b10,
    CSR_OP_CLR  = 2'b11
  } csr_op_e;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned IDX_W    = 5;
  localparam logic [1:0]  RO_FIELD = 2'b11;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_unit_pkg::*;
(
  input  logic [2:0]       funct3_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] rs1_idx_i,
  output csr_op_e          op_o,
  output logic             imm_sel_o,
  output logic             fn_ok_o,
  output logic             rd_req_o,
  output logic             wr_req_o
);
  logic rd_zero, rs1_zero;

  assign op_o      = csr_op_e'(funct3_i[1:0]);
  assign imm_sel_o = funct3_i[2];
  assign fn_ok_o   = (op_o != CSR_OP_NONE);
  assign rd_zero   = (rd_idx_i == '0);
  assign rs1_zero  = (rs1_idx_i == '0);

  // Suppression depends on indices only; the immediate lives in the rs1 field
  always_comb begin
    rd_req_o = 1'b0;
    wr_req_o = 1'b0;
    unique case (op_o)
      CSR_OP_SWAP: begin
        rd_req_o = !rd_zero;
        wr_req_o = 1'b1;
      end
      CSR_OP_SET, CSR_OP_CLR: begin
        rd_req_o = 1'b1;
        wr_req_o = !rs1_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/csr_addr_match.sv
module csr_addr_match
  import csr_unit_pkg::*;
#(
  parameter int unsigned                      NUM_CSR  = 4,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0]   CSR_ADDR = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_CSR-1:0] sel_o,
  output logic               hit_o,
  output logic               ro_o
);
  for (genvar g = 0; g < NUM_CSR; g++) begin : g_cmp
    assign sel_o[g] = (addr_i == CSR_ADDR[g]);
  end

  assign hit_o = |sel_o;
  assign ro_o  = (addr_i[ADDR_W-1 -: 2] == RO_FIELD);
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
  import csr_unit_pkg::*;
#(
  parameter int unsigned                   XLEN      = 32,
  parameter int unsigned                   NUM_CSR   = 4,
  parameter logic [NUM_CSR-1:0][XLEN-1:0]  CSR_RESET = '0,
  parameter logic [NUM_CSR-1:0][XLEN-1:0]  CSR_WMASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CSR-1:0] sel_i,
  input  logic               we_i,
  input  csr_op_e            op_i,
  input  logic [XLEN-1:0]    operand_i,
  output logic [XLEN-1:0]    old_o,
  output logic [XLEN-1:0]    new_o
);
  logic [NUM_CSR-1:0][XLEN-1:0] q;
  logic [XLEN-1:0]              mask;
  logic [XLEN-1:0]              eff;

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q[g] <= CSR_RESET[g];
      else if (we_i && sel_i[g])  q[g] <= new_o;
    end
  end

  // One-hot select: OR-reduce contents and masks
  always_comb begin
    old_o = '0;
    mask  = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (sel_i[i]) begin
        old_o = old_o | q[i];
        mask  = mask  | CSR_WMASK[i];
      end
    end
  end

  assign eff = operand_i & mask;

  always_comb begin
    unique case (op_i)
      CSR_OP_SWAP: new_o = (old_o & ~mask) | eff;
      CSR_OP_SET:  new_o = old_o | eff;
      CSR_OP_CLR:  new_o = old_o & ~eff;
      default:     new_o = old_o;
    endcase
  end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csr_unit_pkg::*;
#(
  parameter int unsigned                   XLEN      = 32,
  parameter int unsigned                   NUM_CSR   = 4,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDR = {12'hC01, 12'h7C0, 12'h300, 12'h340},
  parameter logic [NUM_CSR-1:0][XLEN-1:0]  CSR_RESET = {32'h1234_5678, 32'h0000_00A5,
                                                        32'h0000_1800, 32'h0000_0000},
  parameter logic [NUM_CSR-1:0][XLEN-1:0]  CSR_WMASK = {32'h0000_0000, 32'h0000_00FF,
                                                        32'h0000_0088, 32'hFFFF_FFFF}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       funct3_i,
  input  logic [11:0]      csr_addr_i,
  input  logic [4:0]       rd_idx_i,
  input  logic [4:0]       rs1_idx_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic             re_o,
  output logic             we_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic             illegal_o
);
  localparam int unsigned PAD_W = XLEN - IDX_W;

  csr_op_e            op;
  logic               imm_sel, fn_ok, rd_req, wr_req;
  logic [NUM_CSR-1:0] sel;
  logic               hit, ro;
  logic [XLEN-1:0]    operand, old_val, new_val;
  logic               fault;

  csr_op_decode u_dec (
    .funct3_i  (funct3_i),
    .rd_idx_i  (rd_idx_i),
    .rs1_idx_i (rs1_idx_i),
    .op_o      (op),
    .imm_sel_o (imm_sel),
    .fn_ok_o   (fn_ok),
    .rd_req_o  (rd_req),
    .wr_req_o  (wr_req)
  );

  csr_addr_match #(
    .NUM_CSR  (NUM_CSR),
    .CSR_ADDR (CSR_ADDR)
  ) u_match (
    .addr_i (csr_addr_i),
    .sel_o  (sel),
    .hit_o  (hit),
    .ro_o   (ro)
  );

  assign operand = imm_sel ? {{PAD_W{1'b0}}, rs1_idx_i} : rs1_val_i;

  // Read-only fault only when a write would actually happen
  assign fault     = !fn_ok || !hit || (wr_req && ro);
  assign illegal_o = valid_i && fault;
  assign re_o      = valid_i && !fault && rd_req;
  assign we_o      = valid_i && !fault && wr_req;

  csr_reg_bank #(
    .XLEN      (XLEN),
    .NUM_CSR   (NUM_CSR),
    .CSR_RESET (CSR_RESET),
    .CSR_WMASK (CSR_WMASK)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .we_i      (we_o),
    .op_i      (op),
    .operand_i (operand),
    .old_o     (old_val),
    .new_o     (new_val)
  );

  assign rdata_o = re_o ? old_val : '0;
  assign wdata_o = new_val;
endmodule

// File: rtl/csr_exec_unit_chk.sv
module csr_exec_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      funct3_i,
  input logic [11:0]     csr_addr_i,
  input logic [4:0]      rd_idx_i,
  input logic [4:0]      rs1_idx_i,
  input logic [XLEN-1:0] rdata_o,
  input logic            re_o,
  input logic            we_o,
  input logic            illegal_o
);
  logic set_clr;
  assign set_clr = valid_i && (funct3_i[1:0] == 2'b10 || funct3_i[1:0] == 2'b11);

  assert_bad_funct3_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && funct3_i[1:0] == 2'b00) |-> (illegal_o && !re_o && !we_o));

  assert_swap_rd0_no_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && funct3_i[1:0] == 2'b01 && rd_idx_i == 5'd0) |-> (!re_o && rdata_o == '0));

  assert_rs1_zero_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_clr && rs1_idx_i == 5'd0) |-> !we_o);

  assert_set_clr_reads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_clr && !illegal_o) |-> re_o);

  assert_ro_never_written_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i[11:10] == 2'b11) |-> !we_o);

  assert_illegal_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!re_o && !we_o));

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!re_o && !we_o && !illegal_o));
endmodule

bind csr_exec_unit csr_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .funct3_i   (funct3_i),
  .csr_addr_i (csr_addr_i),
  .rd_idx_i   (rd_idx_i),
  .rs1_idx_i  (rs1_idx_i),
  .rdata_o    (rdata_o),
  .re_o       (re_o),
  .we_o       (we_o),
  .illegal_o  (illegal_o)
);

// File: tb/csr_exec_unit_test.sv
module csr_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  funct3_i = '0;
  logic [11:0] csr_addr_i = '0;
  logic [4:0]  rd_idx_i = '0;
  logic [4:0]  rs1_idx_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [31:0] rdata_o, wdata_o;
  logic        re_o, we_o, illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  csr_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .funct3_i(funct3_i),
    .csr_addr_i(csr_addr_i), .rd_idx_i(rd_idx_i), .rs1_idx_i(rs1_idx_i),
    .rs1_val_i(rs1_val_i), .rdata_o(rdata_o), .re_o(re_o), .we_o(we_o),
    .wdata_o(wdata_o), .illegal_o(illegal_o)
  );

  // Model built from R11 defaults
  localparam logic [11:0] M_ADDR [4] = '{12'h340, 12'h300, 12'h7C0, 12'hC01};
  localparam logic [31:0] M_RST  [4] = '{32'h0, 32'h1800, 32'hA5, 32'h1234_5678};
  localparam logic [31:0] M_MASK [4] = '{32'hFFFF_FFFF, 32'h88, 32'hFF, 32'h0};
  logic [31:0] mdl [4];

  task automatic mdl_reset();
    for (int i = 0; i < 4; i++) mdl[i] = M_RST[i];
  endtask

  // {req(4), funct3(3), csr(12), rd(5), rs1(5), val(32)}
  localparam int NV = 19;
  localparam logic [60:0] VEC [NV] = '{
    {4'd8,  3'b010, 12'h340, 5'd1, 5'd0,  32'h0},          // R8 plain read
    {4'd2,  3'b001, 12'h340, 5'd2, 5'd5,  32'hDEAD_BEEF},  // R2 swap
    {4'd3,  3'b010, 12'h300, 5'd3, 5'd6,  32'hFFFF_FFFF},  // R3 set masked
    {4'd3,  3'b011, 12'h300, 5'd3, 5'd6,  32'h0000_0008},  // R3 clear masked
    {4'd11, 3'b001, 12'h7C0, 5'd1, 5'd7,  32'h0000_1234},  // R11 mask holds upper bits
    {4'd7,  3'b110, 12'h340, 5'd1, 5'd31, 32'hFFFF_0000},  // R7 set imm
    {4'd7,  3'b111, 12'h340, 5'd1, 5'd16, 32'hFFFF_FFFF},  // R7 clear imm
    {4'd7,  3'b101, 12'h7C0, 5'd0, 5'd21, 32'hFFFF_FFFF},  // R7 swap imm rd0
    {4'd2,  3'b001, 12'h340, 5'd4, 5'd0,  32'h0},          // R2 swap from x0
    {4'd5,  3'b010, 12'h7C0, 5'd1, 5'd9,  32'h0},          // R5 zero value, nonzero idx
    {4'd4,  3'b011, 12'h300, 5'd1, 5'd0,  32'hFFFF_FFFF},  // R4 clear via x0
    {4'd4,  3'b010, 12'hC01, 5'd1, 5'd0,  32'h0},          // R4 read-only read legal
    {4'd9,  3'b001, 12'hC01, 5'd0, 5'd3,  32'h1},          // R9 swap on RO
    {4'd9,  3'b110, 12'hC01, 5'd1, 5'd1,  32'h0},          // R9 set imm on RO
    {4'd10, 3'b010, 12'h123, 5'd1, 5'd0,  32'h0},          // R10 unimplemented
    {4'd1,  3'b000, 12'h340, 5'd1, 5'd1,  32'h5},          // R1 funct3 000
    {4'd1,  3'b100, 12'h340, 5'd1, 5'd1,  32'h5},          // R1 funct3 100
    {4'd12, 3'b010, 12'h340, 5'd1, 5'd0,  32'h0},          // R12 readback
    {4'd6,  3'b011, 12'h300, 5'd0, 5'd4,  32'h80}          // R6 read with rd0
  };

  task automatic run_op(input int req, input logic [2:0] f3, input logic [11:0] a,
                        input logic [4:0] rd, input logic [4:0] rs1, input logic [31:0] v);
    int idx;
    logic ill, re, we;
    logic [31:0] opnd, old, nw, eff, exp_rd;
    @(negedge clk);
    valid_i = 1'b1; funct3_i = f3; csr_addr_i = a;
    rd_idx_i = rd; rs1_idx_i = rs1; rs1_val_i = v;
    #2;
    idx = -1;
    for (int i = 0; i < 4; i++) if (M_ADDR[i] == a) idx = i;
    opnd = f3[2] ? {27'd0, rs1} : v;
    we   = (f3[1:0] == 2'b01) || (rs1 != 5'd0);
    re   = (f3[1:0] != 2'b01) || (rd != 5'd0);
    ill  = (f3[1:0] == 2'b00) || (idx < 0) || (we && a[11:10] == 2'b11);
    re   = re && !ill;
    we   = we && !ill;
    old  = (idx >= 0) ? mdl[idx] : 32'h0;
    eff  = (idx >= 0) ? (opnd & M_MASK[idx]) : 32'h0;
    case (f3[1:0])
      2'b01:   nw = (idx >= 0) ? ((old & ~M_MASK[idx]) | eff) : old;
      2'b10:   nw = old | eff;
      default: nw = old & ~eff;
    endcase
    exp_rd = re ? old : 32'h0;
    n_chk++;
    if (illegal_o !== ill || re_o !== re || we_o !== we || rdata_o !== exp_rd ||
        (we && wdata_o !== nw)) begin
      n_bad++;
      $display("FAIL R%0d: got ill=%b re=%b we=%b rd=%h wd=%h exp ill=%b re=%b we=%b rd=%h wd=%h",
               req, illegal_o, re_o, we_o, rdata_o, wdata_o, ill, re, we, exp_rd, nw);
    end
    if (we) mdl[idx] = nw;
  endtask

  task automatic idle_check();
    @(negedge clk);
    valid_i = 1'b0; funct3_i = 3'b001; csr_addr_i = 12'h340; rs1_idx_i = 5'd3;
    rs1_val_i = 32'hFFFF_FFFF;
    #2;
    n_chk++;
    if (re_o !== 1'b0 || we_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R13: got re=%b we=%b ill=%b exp 0 0 0", re_o, we_o, illegal_o);
    end
  endtask

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R11 reset values
    for (int i = 0; i < 4; i++) run_op(11, 3'b010, M_ADDR[i], 5'd1, 5'd0, 32'h0);
    for (int k = 0; k < NV; k++)
      run_op(int'(VEC[k][60:57]), VEC[k][56:54], VEC[k][53:42], VEC[k][41:37],
             VEC[k][36:32], VEC[k][31:0]);
    // R13 idle cycle must not commit; then confirm contents unchanged
    idle_check();
    run_op(13, 3'b010, 12'h340, 5'd1, 5'd0, 32'h0);
    // R12 write then immediate readback on partly writable CSR
    run_op(12, 3'b001, 12'h300, 5'd1, 5'd2, 32'hFFFF_FFFF);
    run_op(12, 3'b010, 12'h300, 5'd1, 5'd0, 32'h0);
    // R9 rejected write left RO contents intact
    run_op(9, 3'b010, 12'hC01, 5'd1, 5'd0, 32'h0);
    // R11 reset mid-run restores defaults
    @(negedge clk); valid_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1; mdl_reset();
    for (int i = 0; i < 4; i++) run_op(11, 3'b010, M_ADDR[i], 5'd1, 5'd0, 32'h0);
    @(negedge clk); valid_i = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule